// File: doc/BRIEF.md
# Operand Bypass and Load-Hazard Interlock

This block is the hazard control for a five-stage integer pipeline whose stages are fetch, decode, execute, memory and write-back. It looks at the register numbers held in the stage registers, together with each stage's register-write and memory-read flags. From these it drives the select codes of the two multiplexers in front of the ALU. An operand can come from the value read in decode, from the result waiting in the execute/memory register, or from the result waiting in the memory/write-back register. Register writes happen only in write-back and register reads happen only in decode, so read-after-write is the only kind of hazard that can occur.

A result that comes from a load is not ready in time for the instruction right behind it. When the block sees this case, it requests a single stall cycle. The program counter and the fetch/decode register keep their contents, and the control fields of the decode/execute register are cleared, so a bubble enters the pipeline. One cycle later, the loaded value reaches the ALU through the memory/write-back path. The register file writes before it reads within a cycle, so a third dependent instruction reads the correct value directly and no separate path is needed for it. The block also chooses which instruction field names the destination register that travels down the pipeline.

Top module: `fwd_stall_unit`

## Requirements
- R1: selA is 2'b10 when memRegWrite is high, memDst is nonzero and memDst equals exRs.
- R2: selA is 2'b01 when wbRegWrite is high, wbDst is nonzero, wbDst equals exRs and R1 does not apply.
- R3: When the memory stage and the write-back stage both match a source register, the memory-stage code 2'b10 wins.
- R4: Register 0 is never bypassed, and a stage whose register-write flag is low is never used as a source.
- R5: selB follows the rules of R1 to R4, applied to exRt and not exRs. This covers store data as well as ALU operands.
- R6: In every other case a select is 2'b00, which picks the register-file value. The code 2'b11 never appears.
- R7: holdPc, holdIfId and bubbleIdEx are all high when exMemRead is high, exDst is nonzero and exDst equals idRs or idRt.
- R8: No stall is raised when exMemRead is low or when exDst is 0.
- R9: idDst equals idRd when idUseRd is high (register-register operations), and equals idRt otherwise (loads and immediate operations).
- R10: holdPc, holdIfId and bubbleIdEx always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | REG_W | First source register of the instruction in decode |
| idRt | input | REG_W | Second source register of the instruction in decode |
| idRd | input | REG_W | Destination field used by register-register operations |
| idUseRd | input | 1 | High for a register-register operation |
| exRs | input | REG_W | First source register of the instruction in execute |
| exRt | input | REG_W | Second source register of the instruction in execute |
| exDst | input | REG_W | Destination register of the instruction in execute |
| exMemRead | input | 1 | The instruction in execute is a load |
| memDst | input | REG_W | Destination register held in the execute/memory register |
| memRegWrite | input | 1 | Register-write flag of the memory stage |
| wbDst | input | REG_W | Destination register held in the memory/write-back register |
| wbRegWrite | input | 1 | Register-write flag of the write-back stage |
| idDst | output | REG_W | Selected destination register number |
| selA | output | 2 | Select code for the first ALU input |
| selB | output | 2 | Select code for the second ALU input |
| holdPc | output | 1 | Keep the program counter unchanged |
| holdIfId | output | 1 | Keep the fetch/decode register unchanged |
| bubbleIdEx | output | 1 | Clear the control fields of the decode/execute register |

## Verification
The hardest case to reach is the overlap of several conditions at once. Both later stages can name the same source register, while register 0 or a cleared write flag should hide one or both matches, and both ALU inputs can point at the same register. A pipeline driven by real instruction sequences reaches these combinations only rarely. The bench therefore drives the stage fields directly and sweeps every combination over a four-register subset, covering both write flags and both operands. It then sweeps the load-interlock inputs in the same way.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_W_DEF = 5;
  localparam int NUM_SRC   = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] fromMem;
    logic [NUM_SRC-1:0] fromWb;
    logic               loadUse;
  } hazStrobe_t;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_W = REG_W_DEF
) (
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] idRd,
  input  logic             idUseRd,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] exDst,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memDst,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbRegWrite,
  output logic [REG_W-1:0] idDst,
  output hazStrobe_t       strobe
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] exSrc [NUM_SRC];
  logic memLive, wbLive, exLoadLive;

  assign exSrc[0] = exRs;
  assign exSrc[1] = exRt;

  // A producing stage counts only when it writes a register other than 0
  assign memLive    = memRegWrite && (memDst != ZERO_REG);
  assign wbLive     = wbRegWrite  && (wbDst  != ZERO_REG);
  assign exLoadLive = exMemRead   && (exDst  != ZERO_REG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign strobe.fromMem[i] = memLive && (memDst == exSrc[i]);
    assign strobe.fromWb[i]  = wbLive  && (wbDst  == exSrc[i]);
  end

  assign strobe.loadUse = exLoadLive && ((exDst == idRs) || (exDst == idRt));

  // R9: the destination field depends on the instruction format
  assign idDst = idUseRd ? idRd : idRt;
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  hazStrobe_t strobe,
  output logic [1:0] selA,
  output logic [1:0] selB,
  output logic       holdPc,
  output logic       holdIfId,
  output logic       bubbleIdEx
);
  opSel_e sel [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    always_comb begin
      if (strobe.fromMem[i])     sel[i] = SEL_MEM;  // R3: newer result first
      else if (strobe.fromWb[i]) sel[i] = SEL_WB;
      else                       sel[i] = SEL_RF;
    end
  end

  assign selA       = sel[0];
  assign selB       = sel[1];
  assign holdPc     = strobe.loadUse;
  assign holdIfId   = strobe.loadUse;
  assign bubbleIdEx = strobe.loadUse;

  always_comb begin
    a_r6_no_illegal_sel: assert (selA != 2'b11 && selB != 2'b11)
      else $error("select code 11 produced");
  end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = REG_W_DEF
) (
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] idRd,
  input  logic             idUseRd,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] exDst,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memDst,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbRegWrite,
  output logic [REG_W-1:0] idDst,
  output logic [1:0]       selA,
  output logic [1:0]       selB,
  output logic             holdPc,
  output logic             holdIfId,
  output logic             bubbleIdEx
);
  hazStrobe_t strobe;

  fwd_match #(.REG_W(REG_W)) u_match (
    .idRs(idRs), .idRt(idRt), .idRd(idRd), .idUseRd(idUseRd),
    .exRs(exRs), .exRt(exRt), .exDst(exDst), .exMemRead(exMemRead),
    .memDst(memDst), .memRegWrite(memRegWrite),
    .wbDst(wbDst), .wbRegWrite(wbRegWrite),
    .idDst(idDst), .strobe(strobe)
  );

  fwd_ctrl u_ctrl (
    .strobe(strobe), .selA(selA), .selB(selB),
    .holdPc(holdPc), .holdIfId(holdIfId), .bubbleIdEx(bubbleIdEx)
  );

  always_comb begin
    a_r4_zero_a: assert (exRs != '0 || selA == 2'b00)
      else $error("register 0 bypassed on A");
    a_r4_zero_b: assert (exRt != '0 || selB == 2'b00)
      else $error("register 0 bypassed on B");
    a_r3_mem_first: assert (!(memRegWrite && memDst != '0 && memDst == exRs) || selA == 2'b10)
      else $error("memory-stage result not chosen on A");
    a_r8_no_load_no_stall: assert (exMemRead || !holdPc)
      else $error("stall without a load");
    a_r10_stall_agree: assert (holdPc == holdIfId && holdIfId == bubbleIdEx)
      else $error("stall outputs disagree");
  end
endmodule

// File: tb/tb_fwd_stall_unit.sv
module tb_fwd_stall_unit;
  localparam int W = 5;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] idRs = '0, idRt = '0, idRd = '0, exRs = '0, exRt = '0;
  logic [W-1:0] exDst = '0, memDst = '0, wbDst = '0;
  logic idUseRd = 1'b0, exMemRead = 1'b0, memRegWrite = 1'b0, wbRegWrite = 1'b0;
  logic [W-1:0] idDst;
  logic [1:0] selA, selB;
  logic holdPc, holdIfId, bubbleIdEx;

  int runCnt = 0;
  int failCnt = 0;

  fwd_stall_unit #(.REG_W(W)) dut (
    .idRs(idRs), .idRt(idRt), .idRd(idRd), .idUseRd(idUseRd),
    .exRs(exRs), .exRt(exRt), .exDst(exDst), .exMemRead(exMemRead),
    .memDst(memDst), .memRegWrite(memRegWrite),
    .wbDst(wbDst), .wbRegWrite(wbRegWrite),
    .idDst(idDst), .selA(selA), .selB(selB),
    .holdPc(holdPc), .holdIfId(holdIfId), .bubbleIdEx(bubbleIdEx)
  );

  function automatic logic [1:0] expSel(logic [W-1:0] src);
    if (memRegWrite && memDst != 0 && memDst == src) return 2'b10;
    if (wbRegWrite && wbDst != 0 && wbDst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string selTag(logic [W-1:0] src, logic [1:0] e);
    if (src == 0) return "R4";
    if (e == 2'b10 && wbRegWrite && wbDst == src) return "R3";
    if (e == 2'b10) return "R1";
    if (e == 2'b01) return "R2";
    return "R6";
  endfunction

  task automatic check(string tag, int act, int exp);
    runCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    @(negedge clk);
    #1;
    check("R6 reset selA", selA, 0);
    check("R6 reset selB", selB, 0);
    check("R8 reset stall", holdPc, 0);

    // bypass sweep over registers 0..3 (R1-style cases, B side is R5)
    for (int rs = 0; rs < 4; rs++)
      for (int rt = 0; rt < 4; rt++)
        for (int md = 0; md < 4; md++)
          for (int mw = 0; mw < 2; mw++)
            for (int wd = 0; wd < 4; wd++)
              for (int ww = 0; ww < 2; ww++) begin
                @(negedge clk);
                exRs = W'(rs); exRt = W'(rt); memDst = W'(md);
                memRegWrite = mw[0]; wbDst = W'(wd); wbRegWrite = ww[0];
                #1;
                begin
                  logic [1:0] ea, eb;
                  ea = expSel(exRs);
                  eb = expSel(exRt);
                  check({selTag(exRs, ea), " selA"}, selA, ea);
                  check({selTag(exRt, eb), " selB R5"}, selB, eb);
                end
              end

    // wide register numbers
    @(negedge clk);
    exRs = 5'd31; exRt = 5'd31; memDst = 5'd31; memRegWrite = 1'b1;
    wbDst = 5'd31; wbRegWrite = 1'b1;
    #1;
    check("R3 reg31 selA", selA, 2);
    check("R5 reg31 selB", selB, 2);
    memRegWrite = 1'b0;
    #1;
    check("R2 reg31 selA", selA, 1);

    // load-use sweep
    memRegWrite = 1'b0; wbRegWrite = 1'b0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 4; d++)
          for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            idRs = W'(a); idRt = W'(b); exDst = W'(d); exMemRead = m[0];
            #1;
            begin
              logic e;
              e = m[0] && d != 0 && (d == a || d == b);
              check(e ? "R7 holdPc" : "R8 holdPc", holdPc, e);
              check("R10 holdIfId", holdIfId, e);
              check("R10 bubbleIdEx", bubbleIdEx, e);
            end
          end

    // destination field choice
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        idUseRd = u[0]; idRd = W'(k * 7 + 3); idRt = W'(k * 5 + 1);
        #1;
        check("R9 idDst", idDst, u[0] ? (k * 7 + 3) : (k * 5 + 1));
      end

    finishRun();
  end
endmodule